// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial side of a small byte-addressed nonvolatile memory that answers as an SPI slave in mode 0. The chip-select, clock, data-in and pause inputs are synchronised into the system clock domain. SCK edges are detected there. The serial clock must therefore run well below the system clock. The block shifts in an 8-bit opcode, then address and data bytes, and drives a serial output with a separate output enable for read data and for status reads. The storage is a register array of `DEPTH` bytes: 1024 by default, and 2048 is also a legal setting.

The block keeps a write-enable flag and a busy flag, plus two user status bits that software can write. An array write or a status write is only committed when chip select rises on a byte boundary. The write must also have been enabled when its opcode arrived. A committed write clears the enable flag and starts an internal write cycle of `WCYC` system clocks. During that cycle the status can still be read, but array accesses and status writes are refused. A pause input (active low) freezes the transfer. SCK edges seen while it is low are dropped, and the transfer carries on from the same bit once it is released.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, `so_oe` is 0, and a status read returns 0x00. The status byte layout is: bit 0 busy, bit 1 write-enable flag, bits 3:2 user bits, bits 7:4 zero.
- R2: All bytes travel most significant bit first. SI is taken on SCK rising edges, and SO changes after SCK falling edges. `so_oe` is 1 only while chip select is low, the pause input is high, and read or status data is being shifted out.
- R3: Opcode 0x06 sets the write-enable flag, and opcode 0x04 clears it. Both are accepted even while busy.
- R4: Opcode 0x02 is followed by a 16-bit address, of which only the low log2(DEPTH) bits are used, and then data bytes. The last complete data byte is written when chip select rises with no partial byte pending. If chip select rises in the middle of a byte, nothing is written.
- R5: A write or status-write opcode received while the write-enable flag is clear is ignored, and no busy cycle starts.
- R6: Each committed array write or status write clears the write-enable flag.
- R7: A commit sets the busy bit for `WCYC` system clocks. Status reads (opcode 0x05) work during that time and return fresh status on every byte.
- R8: While busy, the read, write and status-write opcodes are ignored. A refused read never raises `so_oe`.
- R9: Opcode 0x03 with an address returns successive bytes, incrementing the address and wrapping from DEPTH-1 to 0.
- R10: While `hold_n` is low, SCK edges are ignored and `so_oe` is 0. After release, the transfer resumes at the same bit.
- R11: Opcode 0x01 followed by a data byte stores data bits 3:2 into status bits 3:2 when committed.
- R12: Any other opcode makes the block ignore the rest of that transfer, with `so_oe` kept at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Transfer pause, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (0 means tri-stated) |

## Verification
The bench aims at the commit rule. It raises chip select half a byte after a full data byte; a design that commits on any chip-select rise would overwrite the byte. It sends two data bytes; a design that keeps the first instead of the last would return the wrong value. It also starts a read and an enabled write while busy; a design that fails to refuse them would drive SO or change the array. The bench reads across the top of the array, where a design that does not wrap would return a byte from outside the array. It pauses a read in the middle of a byte and sends SCK edges during the pause; a design that counts those edges would return a shifted byte.

// File: rtl/spiee_pkg.sv
// Package: opcodes and protocol states shared by the serial memory slave.
// Assumes: opcodes are full 8-bit values compared exactly.
package spiee_pkg;
    localparam logic [7:0] OP_WSTAT = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_RSTAT = 8'h05;
    localparam logic [7:0] OP_WEN   = 8'h06;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_STAT_OUT,
        ST_STAT_IN,
        ST_IGNORE
    } spiee_state_e;
endpackage

// File: rtl/spiee_insync.sv
// Module: multi-stage synchroniser for a vector of slow asynchronous inputs.
// Assumes: every bit passes the same number of stages, so the relative order
// of input changes spaced at least one clock apart is kept.
module spiee_insync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one register stage of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else if (g == 0) stage_q[g] <= d;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spiee_busy_timer.sv
// Module: internal write-cycle timer; busy stays high for WCYC clocks after start.
// Assumes: start is not pulsed while busy (the front end refuses commits then).
module spiee_busy_timer #(
    parameter int WCYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(WCYC + 1);

    logic [CW-1:0] left_q;

    // Purpose: load the cycle count on start and count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) left_q <= '0;
        else if (start) left_q <= CW'(WCYC);
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/spiee_array.sv
// Module: byte storage with one synchronous write port and one combinational read port.
// Assumes: contents are not reset (they model nonvolatile cells); DEPTH is a power of two.
module spiee_array #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    // Purpose: store one byte when a write is committed.
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/spi_eeprom_slave.sv
// Module: SPI mode-0 slave front end of a byte-addressed nonvolatile memory.
// Decodes opcodes, gathers address/data, drives SO for reads and status reads,
// and commits writes on chip-select rise at a byte boundary.
// Assumes: SCK is at least ~8x slower than clk; hold_n changes only while SCK is low.
module spi_eeprom_slave
    import spiee_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int WCYC        = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    localparam int AW = $clog2(DEPTH);

    logic [3:0] pins_q;
    logic       cs_q, hold_q, sck_q, si_q;
    logic       sck_d, cs_d;
    logic       run, rise, fall, cs_rise, byte_done;
    logic [7:0] byte_in;

    spiee_state_e st;
    logic [2:0]    bitcnt;
    logic [6:0]    shreg;
    logic [7:0]    addr_hi;
    logic          is_wr;
    logic [7:0]    wbuf;
    logic          have_data;
    logic          wel;
    logic [1:0]    prot;
    logic [AW-1:0] ptr;
    logic [6:0]    obuf;
    logic [2:0]    ocnt;
    logic          out_act;
    logic          so_q, oe_q;
    logic          busy, mem_we, stat_we, commit;
    logic [7:0]    rdata, stat_byte, load_byte;
    logic [15:0]   full_addr;

    spiee_insync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, hold_n, sck, si}), .q(pins_q)
    );

    assign cs_q   = pins_q[3];
    assign hold_q = pins_q[2];
    assign sck_q  = pins_q[1];
    assign si_q   = pins_q[0];

    // Purpose: remember previous SCK and chip-select levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_q;
            cs_d  <= cs_q;
        end
    end

    assign run       = !cs_q && hold_q;
    assign rise      = run && sck_q && !sck_d;
    assign fall      = run && !sck_q && sck_d;
    assign cs_rise   = cs_q && !cs_d;
    assign byte_in   = {shreg, si_q};
    assign byte_done = rise && (bitcnt == 3'd7);
    assign full_addr = {addr_hi, byte_in};

    assign mem_we  = cs_rise && (st == ST_WDATA) && have_data && (bitcnt == 3'd0);
    assign stat_we = cs_rise && (st == ST_STAT_IN) && have_data && (bitcnt == 3'd0);
    assign commit  = mem_we || stat_we;

    assign stat_byte = {4'b0000, prot, wel, busy};
    assign load_byte = (st == ST_RDATA) ? rdata : stat_byte;

    spiee_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk), .we(mem_we), .addr(ptr), .wdata(wbuf), .rdata(rdata)
    );

    spiee_busy_timer #(.WCYC(WCYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
    );

    // Purpose: protocol state machine, input shifting, output shifting and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_CMD;
            bitcnt    <= '0;
            shreg     <= '0;
            addr_hi   <= '0;
            is_wr     <= 1'b0;
            wbuf      <= '0;
            have_data <= 1'b0;
            wel       <= 1'b0;
            prot      <= '0;
            ptr       <= '0;
            obuf      <= '0;
            ocnt      <= '0;
            out_act   <= 1'b0;
            so_q      <= 1'b0;
        end else if (cs_q) begin
            st        <= ST_CMD;
            bitcnt    <= '0;
            have_data <= 1'b0;
            ocnt      <= '0;
            out_act   <= 1'b0;
            if (commit) wel <= 1'b0;
            if (stat_we) prot <= wbuf[3:2];
        end else begin
            if (rise) begin
                shreg  <= byte_in[6:0];
                bitcnt <= bitcnt + 1'b1;
            end
            if (byte_done) begin
                unique case (st)
                    ST_CMD: begin
                        unique case (byte_in)
                            OP_WEN:   begin wel <= 1'b1; st <= ST_IGNORE; end
                            OP_WDIS:  begin wel <= 1'b0; st <= ST_IGNORE; end
                            OP_RSTAT: st <= ST_STAT_OUT;
                            OP_WSTAT: st <= (wel && !busy) ? ST_STAT_IN : ST_IGNORE;
                            OP_READ:  begin
                                st    <= busy ? ST_IGNORE : ST_ADDR;
                                is_wr <= 1'b0;
                            end
                            OP_WRITE: begin
                                st    <= (wel && !busy) ? ST_ADDR : ST_IGNORE;
                                is_wr <= 1'b1;
                            end
                            default:  st <= ST_IGNORE;
                        endcase
                        addr_hi <= '0;
                    end
                    ST_ADDR: begin
                        if (!have_data) begin
                            addr_hi   <= byte_in;
                            have_data <= 1'b1;
                        end else begin
                            ptr       <= full_addr[AW-1:0];
                            have_data <= 1'b0;
                            st        <= is_wr ? ST_WDATA : ST_RDATA;
                        end
                    end
                    ST_WDATA, ST_STAT_IN: begin
                        wbuf      <= byte_in;
                        have_data <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (fall && (st == ST_RDATA || st == ST_STAT_OUT)) begin
                out_act <= 1'b1;
                ocnt    <= ocnt + 1'b1;
                if (ocnt == 3'd0) begin
                    so_q <= load_byte[7];
                    obuf <= load_byte[6:0];
                    if (st == ST_RDATA) ptr <= ptr + 1'b1;
                end else begin
                    so_q <= obuf[6];
                    obuf <= {obuf[5:0], 1'b0};
                end
            end
        end
    end

    // Purpose: register the output enable from select, pause and shifting state.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else oe_q <= !cs_q && hold_q && out_act;
    end

    assign so    = so_q;
    assign so_oe = oe_q;
endmodule

// File: rtl/spiee_checker.sv
// Module: property checker bound into the serial memory slave.
// Assumes: connected to the synchronised pin levels and internal flags of the top.
module spiee_checker #(
    parameter int WCYC = 256
) (
    input logic clk,
    input logic rst_n,
    input logic cs_q,
    input logic hold_q,
    input logic so_oe,
    input logic busy,
    input logic wel,
    input logic mem_we
);
    int unsigned busy_run;

    // Purpose: count consecutive busy cycles to bound the write cycle length.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else busy_run <= 0;
    end

    a_r2_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> !so_oe);

    a_r10_oe_off_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_q |=> !so_oe);

    a_r5_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wel && !busy));

    a_r6_wel_cleared_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !wel);

    a_r7_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> busy);

    a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= WCYC);
endmodule

bind spi_eeprom_slave spiee_checker #(.WCYC(WCYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .hold_q(hold_q),
    .so_oe(so_oe), .busy(busy), .wel(wel), .mem_we(mem_we)
);

// File: tb/spi_eeprom_slave_test.sv
module spi_eeprom_slave_test;
    localparam int DEPTH = 1024;
    localparam int WCYC  = 2000;
    localparam int HALF  = 8;
    localparam int NVEC  = 6;
    // {address as sent, data}
    localparam logic [23:0] VEC [NVEC] = '{
        {16'h0000, 8'h5A}, {16'h03FF, 8'hA5}, {16'hFC12, 8'h3C},
        {16'h0155, 8'hC3}, {16'h8200, 8'h0F}, {16'h7C12, 8'hE1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;
    int   checks = 0, fails = 0;

    always #5 clk = ~clk;

    spi_eeprom_slave #(.DEPTH(DEPTH), .WCYC(WCYC)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xbit(input logic b, output logic got, output logic oe);
        si = b;
        tick(HALF);
        got = so;
        oe  = so_oe;
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx,
                         output logic oe_all, output logic oe_any);
        logic g, o;
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            xbit(tx[i], g, o);
            rx[i]  = g;
            oe_all = oe_all & o;
            oe_any = oe_any | o;
        end
    endtask

    task automatic cs_on();
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic cs_off();
        tick(4);
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r; logic a, b;
        cs_on(); xbyte(op, r, a, b); cs_off();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r; logic a, b;
        cs_on(); xbyte(8'h05, r, a, b); xbyte(8'h00, s, a, b); cs_off();
    endtask

    task automatic wr_raw(input logic [15:0] ad, input logic [7:0] d);
        logic [7:0] r; logic a, b;
        cs_on();
        xbyte(8'h02, r, a, b); xbyte(ad[15:8], r, a, b);
        xbyte(ad[7:0], r, a, b); xbyte(d, r, a, b);
        cs_off();
    endtask

    task automatic rd_byte(input logic [15:0] ad, output logic [7:0] d, output logic oe_all,
                           output logic oe_any);
        logic [7:0] r; logic a, b;
        cs_on();
        xbyte(8'h03, r, a, b); xbyte(ad[15:8], r, a, b); xbyte(ad[7:0], r, a, b);
        xbyte(8'h00, d, oe_all, oe_any);
        cs_off();
    endtask

    task automatic wait_idle();
        tick(WCYC + 100);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] s, d, d2, r;
        logic a, b, g, o;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        check("R1 so_oe after reset", {7'b0, so_oe}, 8'h00);
        rdsr(s);
        check("R1 status after reset", s, 8'h00);

        // R3: enable / disable flag
        cmd1(8'h06); rdsr(s);
        check("R3 status after 0x06", s, 8'h02);
        cmd1(8'h04); rdsr(s);
        check("R3 status after 0x04", s, 8'h00);

        // R4 R2: vector table of writes and read-backs (upper address bits ignored)
        for (int i = 0; i < NVEC; i++) begin
            cmd1(8'h06);
            wr_raw(VEC[i][23:8], VEC[i][7:0]);
            wait_idle();
            rd_byte({6'b0, VEC[i][17:8]}, d, a, b);
            check($sformatf("R4 readback vector %0d", i), d, VEC[i][7:0]);
            check($sformatf("R2 so_oe during data vector %0d", i), {7'b0, a}, 8'h01);
        end

        // R5: write without enable is dropped, no busy cycle
        wr_raw(16'h0012, 8'h99);
        rdsr(s);
        check("R5 status after refused write", s, 8'h00);
        rd_byte(16'h0012, d, a, b);
        check("R5 array unchanged", d, 8'hE1);

        // R4: chip select rises mid-byte after a full data byte
        cmd1(8'h06);
        cs_on();
        xbyte(8'h02, r, a, b); xbyte(8'h01, r, a, b); xbyte(8'h55, r, a, b);
        xbyte(8'h44, r, a, b);
        for (int i = 0; i < 4; i++) xbit(1'b1, g, o);
        cs_off();
        rdsr(s);
        check("R4 no commit mid-byte status", s, 8'h02);
        rd_byte(16'h0155, d, a, b);
        check("R4 no commit mid-byte data", d, 8'hC3);
        cmd1(8'h04);

        // R7 R6 R8: busy window
        cmd1(8'h06);
        wr_raw(16'h0200, 8'h77);
        rdsr(s);
        check("R7 R6 status during busy", s, 8'h01);
        rd_byte(16'h0000, d, a, b);
        check("R8 read refused while busy so_oe", {7'b0, b}, 8'h00);
        cmd1(8'h06);
        wr_raw(16'h0155, 8'h99);
        wait_idle();
        rd_byte(16'h0155, d, a, b);
        check("R8 write refused while busy", d, 8'hC3);
        rd_byte(16'h0200, d, a, b);
        check("R4 committed before busy", d, 8'h77);
        rdsr(s);
        check("R8 flag kept after refused write", s, 8'h02);
        cmd1(8'h04);

        // R9: sequential read wraps from top to zero
        cs_on();
        xbyte(8'h03, r, a, b); xbyte(8'h03, r, a, b); xbyte(8'hFF, r, a, b);
        xbyte(8'h00, d, a, b); xbyte(8'h00, d2, a, b);
        cs_off();
        check("R9 top byte", d, 8'hA5);
        check("R9 wrapped byte", d2, 8'h5A);

        // R10: pause mid-byte with SCK activity in between
        cs_on();
        xbyte(8'h03, r, a, b); xbyte(8'h00, r, a, b); xbyte(8'h12, r, a, b);
        for (int i = 7; i >= 5; i--) begin xbit(1'b0, g, o); d[i] = g; end
        tick(2);
        hold_n = 1'b0;
        tick(6);
        o = so_oe;
        check("R10 so_oe low in pause", {7'b0, o}, 8'h00);
        for (int k = 0; k < 2; k++) begin sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF); end
        hold_n = 1'b1;
        tick(6);
        a = 1'b1;
        for (int i = 4; i >= 0; i--) begin xbit(1'b0, g, o); d[i] = g; a = a & o; end
        cs_off();
        check("R10 byte after resume", d, 8'hE1);
        check("R10 so_oe after resume", {7'b0, a}, 8'h01);

        // R11 R6: status write
        cmd1(8'h06);
        cs_on(); xbyte(8'h01, r, a, b); xbyte(8'hFF, r, a, b); cs_off();
        rdsr(s);
        check("R11 R6 status right after write", s, 8'h0D);
        wait_idle();
        rdsr(s);
        check("R11 status after cycle", s, 8'h0C);
        cs_on(); xbyte(8'h01, r, a, b); xbyte(8'h00, r, a, b); cs_off();
        rdsr(s);
        check("R5 status write without flag", s, 8'h0C);

        // R4: last of several data bytes is kept
        cmd1(8'h06);
        cs_on();
        xbyte(8'h02, r, a, b); xbyte(8'h01, r, a, b); xbyte(8'h55, r, a, b);
        xbyte(8'h11, r, a, b); xbyte(8'h22, r, a, b);
        cs_off();
        wait_idle();
        rd_byte(16'h0155, d, a, b);
        check("R4 last data byte wins", d, 8'h22);

        // R12: unknown opcode
        cs_on();
        xbyte(8'hAB, r, a, b); xbyte(8'h00, r, a, g); xbyte(8'h00, r, a, o);
        cs_off();
        check("R12 so_oe never high", {7'b0, g | o}, 8'h00);
        rdsr(s);
        check("R12 status unchanged", s, 8'h0C);

        finish_run();
    end
endmodule